// File: doc/BRIEF.md
# Serializer with Loopback Wrap

This block turns a stream of 10-bit transmission characters into a serial bit stream. A character is taken in on every byte strobe and placed in a small elastic FIFO. A shifter then sends it out one bit per bit strobe, least significant bit first. The bit strobe runs at ten times the byte-strobe rate, so one character fills exactly ten bit slots. The PLL that would make both strobes is outside the block. It appears here only as a lock input and the two strobes, which are enables on one fast system clock. The line code is also outside the block.

Characters arrive at a fixed rate set by the byte strobe, and the serial side drains them at the same average rate. For this reason the data input has no valid/ready handshake: the byte strobe is the only qualifier, and the block never pushes back. Rate mismatch is absorbed by the FIFO. The FIFO starts half full, with two zero characters, so it can take drift in either direction. If the FIFO runs dry or fills up, a sticky error flag is raised and the pointers are put back half a buffer apart.

The differential output pair has fixed levels whenever it carries no data. It is held at positive-low/negative-high until the PLL reports lock and while transmit reset is asserted. While loopback is on, both legs are held high and the serial stream goes out on a separate wrap port that feeds the receiver.

Top module: `sxw_serializer`

## Requirements
- R1: When `pll_locked` is 1 and `tx_reset` is 0, the value on `tx_word` is written into the FIFO in each clock cycle where `byte_tick` is 1. Characters leave the FIFO in the order they were written.
- R2: Each character is sent over ten consecutive `bit_tick` cycles, bit 0 first and bit 9 last. The serial bit changes only in cycles where `bit_tick` is 1.
- R3: Each time the block becomes active (locked and not in transmit reset), the FIFO holds two all-zero characters. The first 20 serial bits are therefore 0, and after them come the written characters in order.
- R4: Starting one clock after `pll_locked` is 0, `ser_p` is 0 and `ser_n` is 1. The FIFO and shifter are cleared, and `byte_tick` writes nothing.
- R5: Starting one clock after `tx_reset` is 1, `ser_p` is 0 and `ser_n` is 1. The FIFO and shifter are cleared, and `tx_err` is cleared.
- R6: When the block is active and `wrap_en` is 1, both `ser_p` and `ser_n` are 1 one clock later. The serial stream appears on `wrap_ser` instead.
- R7: When the block is active and `wrap_en` is 0, `ser_p` carries the serial bit and `ser_n` is its complement. In that case, and whenever the block is inactive, `wrap_ser` is 0.
- R8: A write while the FIFO holds 4 characters, with no read in the same cycle, is an overflow. The character is dropped, `tx_err` becomes 1, and the FIFO is recentred to hold 2 characters.
- R9: A read of an empty FIFO is an underflow. It sets `tx_err` and recentres the FIFO to hold 2 characters.
- R10: `tx_err` stays at 1 until `rst_n` is 0 or `tx_reset` is 1. Losing lock does not clear it.
- R11: Every output is registered. A serial bit shifted in a `bit_tick` cycle appears on the output pins one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that carries both strobes |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_tick | input | 1 | Byte strobe; `tx_word` is captured in this cycle |
| tx_word | input | 10 | Parallel transmission character |
| bit_tick | input | 1 | Bit strobe at ten times the byte rate |
| pll_locked | input | 1 | Transmit PLL lock indication |
| tx_reset | input | 1 | Transmit reset, active high |
| wrap_en | input | 1 | Loopback enable |
| ser_p | output | 1 | Positive serial leg |
| ser_n | output | 1 | Negative serial leg |
| wrap_ser | output | 1 | Serial stream sent to the receiver in loopback |
| tx_err | output | 1 | Sticky FIFO overflow/underflow flag |

## Verification
A wrong pointer or a wrong count inside the FIFO shows at the ports within one character time, roughly ten bit strobes. It appears either as characters out of order or as a missing or extra zero character at the start of the stream, or as `tx_err` rising on a balanced stream. A fault in the shifter's bit counter shows as a serial stream that slides against the ten-bit character boundaries, so a pattern check catches it within the first real character. Faults in the output-state selection show on `ser_p`/`ser_n`/`wrap_ser` one clock after the control input changes.

// File: rtl/sxw_pkg.sv
package sxw_pkg;
  typedef enum logic [1:0] {
    LINE_PARK = 2'd0,
    LINE_WRAP = 2'd1,
    LINE_DATA = 2'd2
  } line_mode_e;
endpackage

// File: rtl/sxw_fifo.sv
module sxw_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         err_pulse
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PRE = DEPTH / 2;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          ovf, udf;

  assign udf       = pop && (count == '0);
  assign ovf       = push && !pop && (count == CW'(DEPTH));
  assign err_pulse = ovf || udf;
  assign pop_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rd_ptr <= '0;
      wr_ptr <= AW'(PRE);
      count  <= CW'(PRE);
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ovf || udf) begin
      rd_ptr <= wr_ptr - AW'(PRE);
      count  <= CW'(PRE);
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/sxw_shifter.sv
module sxw_shifter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         bit_tick,
  input  logic [W-1:0] load_word,
  output logic         pop,
  output logic         sbit
);
  localparam int CNTW = $clog2(W);

  logic [CNTW-1:0] bit_cnt;
  logic [W-1:0]    shreg;

  assign pop = bit_tick && (bit_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      bit_cnt <= '0;
      shreg   <= '0;
      sbit    <= 1'b0;
    end else if (bit_tick) begin
      if (bit_cnt == '0) begin
        sbit    <= load_word[0];
        shreg   <= load_word >> 1;
        bit_cnt <= CNTW'(1);
      end else begin
        sbit    <= shreg[0];
        shreg   <= shreg >> 1;
        bit_cnt <= (bit_cnt == CNTW'(W - 1)) ? '0 : bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sxw_line_drv.sv
module sxw_line_drv
  import sxw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic wrap_en,
  input  logic sbit,
  output logic ser_p,
  output logic ser_n,
  output logic wrap_ser
);
  line_mode_e mode;

  always_comb begin
    if (!active)      mode = LINE_PARK;
    else if (wrap_en) mode = LINE_WRAP;
    else              mode = LINE_DATA;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_p    <= 1'b0;
      ser_n    <= 1'b1;
      wrap_ser <= 1'b0;
    end else begin
      case (mode)
        LINE_WRAP: begin
          ser_p    <= 1'b1;
          ser_n    <= 1'b1;
          wrap_ser <= sbit;
        end
        LINE_DATA: begin
          ser_p    <= sbit;
          ser_n    <= ~sbit;
          wrap_ser <= 1'b0;
        end
        default: begin
          ser_p    <= 1'b0;
          ser_n    <= 1'b1;
          wrap_ser <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sxw_serializer.sv
module sxw_serializer #(
  parameter int WORD_W     = 10,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_tick,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              bit_tick,
  input  logic              pll_locked,
  input  logic              tx_reset,
  input  logic              wrap_en,
  output logic              ser_p,
  output logic              ser_n,
  output logic              wrap_ser,
  output logic              tx_err
);
  logic              active;
  logic              pop;
  logic              err_pulse;
  logic              sbit;
  logic [WORD_W-1:0] head_word;

  assign active = pll_locked && !tx_reset;

  sxw_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!active),
    .push      (byte_tick && active),
    .push_data (tx_word),
    .pop       (pop),
    .pop_data  (head_word),
    .err_pulse (err_pulse)
  );

  sxw_shifter #(.W(WORD_W)) shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!active),
    .bit_tick  (bit_tick && active),
    .load_word (head_word),
    .pop       (pop),
    .sbit      (sbit)
  );

  sxw_line_drv line_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .wrap_en  (wrap_en),
    .sbit     (sbit),
    .ser_p    (ser_p),
    .ser_n    (ser_n),
    .wrap_ser (wrap_ser)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || tx_reset) tx_err <= 1'b0;
    else if (err_pulse)     tx_err <= 1'b1;
  end
endmodule

// File: rtl/sxw_serializer_chk.sv
module sxw_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic pll_locked,
  input logic tx_reset,
  input logic wrap_en,
  input logic ser_p,
  input logic ser_n,
  input logic wrap_ser,
  input logic tx_err
);
  // R4
  unlocked_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_locked |=> (!ser_p && ser_n));

  // R5
  txreset_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> (!ser_p && ser_n && !tx_err));

  // R6
  wrap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_locked && !tx_reset && wrap_en) |=> (ser_p && ser_n));

  // R7
  data_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_locked && !tx_reset && !wrap_en) |=> (ser_p != ser_n));

  // R7
  wrap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_en || !pll_locked || tx_reset) |=> !wrap_ser);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !tx_reset) |=> tx_err);
endmodule

bind sxw_serializer sxw_serializer_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pll_locked (pll_locked),
  .tx_reset   (tx_reset),
  .wrap_en    (wrap_en),
  .ser_p      (ser_p),
  .ser_n      (ser_n),
  .wrap_ser   (wrap_ser),
  .tx_err     (tx_err)
);

// File: tb/sxw_serializer_tb_top.sv
module sxw_serializer_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_tick = 1'b0;
  logic [9:0] tx_word = '0;
  logic       bit_tick = 1'b0;
  logic       pll_locked = 1'b0;
  logic       tx_reset = 1'b0;
  logic       wrap_en = 1'b0;
  logic       ser_p, ser_n, wrap_ser, tx_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sxw_serializer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_tick  (byte_tick),
    .tx_word    (tx_word),
    .bit_tick   (bit_tick),
    .pll_locked (pll_locked),
    .tx_reset   (tx_reset),
    .wrap_en    (wrap_en),
    .ser_p      (ser_p),
    .ser_n      (ser_n),
    .wrap_ser   (wrap_ser),
    .tx_err     (tx_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [9:0] pattern(input int j, input int seed);
    return 10'((j * 167 + seed * 59 + 10'h2C5) ^ (j << 3));
  endfunction

  task automatic test_reset_state();
    check(!ser_p && ser_n, "R4 reset park", {ser_p, ser_n}, 2'b01);
    check(!wrap_ser && !tx_err, "R7 reset quiet", {wrap_ser, tx_err}, 0);
  endtask

  // Streams n characters; covers R1 R2 R3 R11, plus R6 or R7
  task automatic run_stream(input bit wrap, input int n, input int seed);
    logic [9:0] words[8];
    logic [9:0] got;
    logic [9:0] exp;
    bit legs_ok = 1'b1;
    bit zero_ok = 1'b1;
    int nbits = 10 * n + 20;
    for (int j = 0; j < 8; j++) words[j] = pattern(j, seed);
    pll_locked = 1'b0;
    wrap_en = wrap;
    idle(3);
    pll_locked = 1'b1;
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      bit_tick  = 1'b1;
      byte_tick = ((i % 10) == 0) && ((i / 10) < n);
      tx_word   = words[(i / 10) % 8];
      @(negedge clk);
      bit_tick  = 1'b0;
      byte_tick = 1'b0;
      @(negedge clk);
      got[i % 10] = wrap ? wrap_ser : ser_p;
      if (wrap) begin
        if (!(ser_p && ser_n)) legs_ok = 1'b0;
      end else begin
        if (ser_n == ser_p || wrap_ser) legs_ok = 1'b0;
      end
      if ((i % 10) == 9) begin
        if (i < 20) begin
          if (got != '0) zero_ok = 1'b0;
        end else begin
          exp = words[(i - 20) / 10];
          if (wrap) check(got == exp, "R6 wrap stream order", got, exp);
          else      check(got == exp, "R2 bit order R1 fifo order", got, exp);
        end
      end
    end
    check(zero_ok, "R3 two zero preload characters", zero_ok, 1);
    if (wrap) check(legs_ok, "R6 both legs high", legs_ok, 1);
    else      check(legs_ok, "R7 complement legs and quiet wrap port", legs_ok, 1);
    check(!tx_err, "R11 balanced stream no error", tx_err, 0);
    pll_locked = 1'b0;
    wrap_en = 1'b0;
    @(negedge clk);
    check(!ser_p && ser_n, "R4 park after lock loss", {ser_p, ser_n}, 2'b01);
  endtask

  // Overflow, stickiness across lock loss, transmit reset
  task automatic test_overflow();
    pll_locked = 1'b0;
    idle(2);
    pll_locked = 1'b1;
    tx_word = 10'h3FF;
    byte_tick = 1'b1;
    idle(2);
    check(!tx_err, "R8 full FIFO is no error", tx_err, 0);
    idle(1);
    byte_tick = 1'b0;
    check(tx_err, "R8 overflow sets error", tx_err, 1);
    pll_locked = 1'b0;
    idle(3);
    check(tx_err, "R10 error kept over lock loss", tx_err, 1);
    byte_tick = 1'b1;
    idle(3);
    byte_tick = 1'b0;
    check(!ser_p && ser_n, "R4 unlocked writes ignored, park", {ser_p, ser_n}, 2'b01);
    pll_locked = 1'b1;
    tx_reset = 1'b1;
    idle(1);
    check(!ser_p && ser_n, "R5 tx reset park", {ser_p, ser_n}, 2'b01);
    check(!tx_err, "R5 tx reset clears error", tx_err, 0);
    tx_reset = 1'b0;
    pll_locked = 1'b0;
    idle(1);
  endtask

  // Underflow after the preload drains
  task automatic test_underflow();
    pll_locked = 1'b0;
    idle(2);
    pll_locked = 1'b1;
    for (int i = 0; i < 20; i++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      @(negedge clk);
    end
    check(!tx_err, "R9 two preload reads no error", tx_err, 0);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    check(tx_err, "R9 empty read sets error", tx_err, 1);
    pll_locked = 1'b0;
    idle(1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    test_reset_state();
    run_stream(1'b0, 6, 1);
    run_stream(1'b1, 5, 7);
    run_stream(1'b0, 3, 12);
    test_overflow();
    test_underflow();
    // Unlocked wrap keeps the pair parked
    pll_locked = 1'b0;
    wrap_en = 1'b1;
    idle(2);
    check(!ser_p && ser_n && !wrap_ser, "R4 unlocked overrides wrap",
          {ser_p, ser_n, wrap_ser}, 3'b010);
    wrap_en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule